// File: doc/BRIEF.md
# PCI Host Interrupt Router

This block sits next to a PCI host bridge and gathers the bus's four level-sensitive, active-low interrupt lines into one place. It also gathers the bridge's error and DMA events there. The interrupt lines are asynchronous, so the block synchronises them first. It then masks each line with its own enable and drives system interrupt lines. A hardware strap selects the routing mode. In shared mode every enabled line is ORed onto a single output. In separate mode each line drives its own output, whose index is the base line plus the pin index.

Bridge events such as master abort, target abort, parity error, system error and the two DMA events are held in sticky status bits. Software clears them by writing ones. A single enable gates the subset of those events that count as errors onto an error interrupt output. The control register also carries the bridge's error-response and parity-check enables out to neighbouring logic. The status register also reports the host-slot and master-capability straps.

A small combinational helper answers the slot-rotation question. Given a device's interrupt pin number (1 to 4, with 0 meaning none) and its slot number, it returns the host line the interrupt arrives on.

Top module: `pci_irq_router`

## Requirements
- R1: After reset the control register reads 0, all event bits are 0, and `irq_o` and `err_irq_o` are low.
- R2: The control register sits at byte offset 0. Bits 3:0 enable host lines 0 to 3. Bit 24 drives `err_resp_en_o`, bit 25 is the error-interrupt enable and bit 26 drives `par_chk_en_o`. All other bits read back as 0.
- R3: The status register sits at byte offset 4. Its bit 8+i reads 1 while `pci_int_n[i]` is low, after a two-flop synchroniser, whatever the enables are.
- R4: Event input `evt_i[k]` sets sticky status bit 12+k. The event order is k=0 parity error, 1 target abort, 2 master abort, 3 DMA error, 4 DMA done, 5 system error. A bit stays set until a status write has a 1 in that position. Writing 0 leaves it alone, and a new event wins over a clear in the same cycle.
- R5: When `mode_strap` is 0 or 1, `irq_o[0]` is the OR of all enabled asserted lines and `irq_o[3:1]` stay low.
- R6: When `mode_strap` is 2 or 3, `irq_o[i]` is high exactly when line i is asserted and enabled.
- R7: `err_irq_o` is high while control bit 25 is set and at least one of status bits 12, 13, 14 or 17 is set. It rises on the clock edge that sets the event bit. The DMA bits 15 and 16 never drive it. It drops once the bits are cleared or the enable is removed.
- R8: Status bit 31 reflects `not_host_strap`, bit 30 reflects `mst_cap_strap` and bits 25:24 reflect `mode_strap`. `host_ok_o` is high only when bit 31 is clear and bit 30 is set.
- R9: `host_pin_o` equals ((`dev_pin_i` − 1) + (`slot_i` & 3)) & 3 with `host_pin_vld_o` high when `dev_pin_i` is 1 to 4. For any other `dev_pin_i`, both outputs are 0.
- R10: A write to the status register changes nothing except the event bits, and access to any offset other than 0 and 4 has no effect and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable phase |
| pwrite | input | 1 | APB write |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pci_int_n | input | 4 | PCI interrupt lines, active low, asynchronous |
| evt_i | input | 6 | Bridge event pulses |
| mode_strap | input | 2 | Routing mode strap |
| not_host_strap | input | 1 | Device is not in the host slot |
| mst_cap_strap | input | 1 | Bridge can act as bus master |
| slot_i | input | SLOT_W | Device slot number for rotation |
| dev_pin_i | input | 3 | Device interrupt pin number, 0 = none |
| host_pin_o | output | 2 | Host line the device pin arrives on |
| host_pin_vld_o | output | 1 | Device pin number is valid |
| irq_o | output | 4 | System interrupt lines |
| err_irq_o | output | 1 | Error interrupt |
| err_resp_en_o | output | 1 | Error responses enabled |
| par_chk_en_o | output | 1 | Parity checking enabled |
| host_ok_o | output | 1 | Straps allow host operation |

## Verification
The bench builds the block with its defaults: an 8-bit address, a 5-bit slot number and two synchroniser stages. The 5-bit slot lets slot values beyond 3 show the modulo-4 rotation wrap. The 3-bit device pin field reaches out-of-range pin numbers 5 to 7 as well as 0. The mode strap and the host straps are plain ports, so every mode value and both routing styles are reached without rebuilding.

// File: rtl/pci_irq_pkg.sv
package pci_irq_pkg;
    localparam int NPIN = 4;
    localparam int NEVT = 6;

    localparam int CTRL_ERRRESP = 24;
    localparam int CTRL_ERRIRQ  = 25;
    localparam int CTRL_PARCHK  = 26;

    localparam int ST_PIN_LSB  = 8;
    localparam int ST_EVT_LSB  = 12;
    localparam int ST_MODE_LSB = 24;
    localparam int ST_MCAP     = 30;
    localparam int ST_NOTHOST  = 31;

    // event index: 0 parity, 1 target abort, 2 master abort,
    // 3 dma error, 4 dma done, 5 system error
    localparam logic [NEVT-1:0] ERR_EVT_MASK = 6'b100111;

    typedef struct packed {
        logic [NPIN-1:0] pin_en;
        logic            err_resp;
        logic            err_irq_en;
        logic            par_chk;
    } ctrl_t;

    typedef struct packed {
        ctrl_t           ctrl;
        logic [NEVT-1:0] events;
        logic [NPIN-1:0] irq;
        logic            err_irq;
    } state_t;
endpackage

// File: rtl/pci_irq_sync.sv
module pci_irq_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pci_irq_swizzle.sv
module pci_irq_swizzle #(
    parameter int SLOT_W = 5,
    parameter int NPIN   = 4,
    localparam int PIN_W = $clog2(NPIN),
    localparam int DEV_W = $clog2(NPIN + 1)
) (
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [DEV_W-1:0]  dev_pin_i,
    output logic [PIN_W-1:0]  host_pin_o,
    output logic              host_pin_vld_o
);
    // NPIN must be a power of two: the sum wraps in PIN_W bits
    logic [PIN_W-1:0] dev_idx;

    always_comb begin
        host_pin_vld_o = (dev_pin_i != '0) && (dev_pin_i <= DEV_W'(NPIN));
        dev_idx        = PIN_W'(dev_pin_i - DEV_W'(1));
        host_pin_o     = host_pin_vld_o ? (dev_idx + slot_i[PIN_W-1:0]) : '0;
    end
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
    import pci_irq_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SLOT_W      = 5,
    parameter int SYNC_STAGES = 2,
    localparam int PIN_W      = $clog2(NPIN),
    localparam int DEV_W      = $clog2(NPIN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic [NPIN-1:0]   pci_int_n,
    input  logic [NEVT-1:0]   evt_i,
    input  logic [1:0]        mode_strap,
    input  logic              not_host_strap,
    input  logic              mst_cap_strap,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [DEV_W-1:0]  dev_pin_i,
    output logic [PIN_W-1:0]  host_pin_o,
    output logic              host_pin_vld_o,
    output logic [NPIN-1:0]   irq_o,
    output logic              err_irq_o,
    output logic              err_resp_en_o,
    output logic              par_chk_en_o,
    output logic              host_ok_o
);
    localparam int WIDX_W = ADDR_W - 2;
    localparam logic [WIDX_W-1:0] CTRL_IDX = WIDX_W'(0);
    localparam logic [WIDX_W-1:0] STAT_IDX = WIDX_W'(1);

    state_t st_d, st_q;
    logic [NPIN-1:0] pin_act_s;
    logic [NPIN-1:0] enabled;
    logic [NEVT-1:0] clr_mask;
    logic            wr_en, sel_ctrl, sel_stat, shared_mode;
    logic [31:0]     ctrl_word, stat_word;
    logic            unused_bits;

    pci_irq_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (~pci_int_n),
        .sync_o  (pin_act_s)
    );

    pci_irq_swizzle #(.SLOT_W(SLOT_W), .NPIN(NPIN)) u_swz (
        .slot_i         (slot_i),
        .dev_pin_i      (dev_pin_i),
        .host_pin_o     (host_pin_o),
        .host_pin_vld_o (host_pin_vld_o)
    );

    assign unused_bits = &{1'b0, paddr[1:0]};

    always_comb begin
        wr_en       = psel && penable && pwrite;
        sel_ctrl    = (paddr[ADDR_W-1:2] == CTRL_IDX);
        sel_stat    = (paddr[ADDR_W-1:2] == STAT_IDX);
        shared_mode = ~mode_strap[1];

        st_d = st_q;
        if (wr_en && sel_ctrl) begin
            st_d.ctrl.pin_en     = pwdata[NPIN-1:0];
            st_d.ctrl.err_resp   = pwdata[CTRL_ERRRESP];
            st_d.ctrl.err_irq_en = pwdata[CTRL_ERRIRQ];
            st_d.ctrl.par_chk    = pwdata[CTRL_PARCHK];
        end

        clr_mask    = (wr_en && sel_stat) ? pwdata[ST_EVT_LSB +: NEVT] : '0;
        st_d.events = (st_q.events & ~clr_mask) | evt_i;

        enabled = pin_act_s & st_d.ctrl.pin_en;
        if (shared_mode) st_d.irq = {{(NPIN-1){1'b0}}, |enabled};
        else             st_d.irq = enabled;

        st_d.err_irq = st_d.ctrl.err_irq_en && |(st_d.events & ERR_EVT_MASK);

        ctrl_word = '0;
        ctrl_word[NPIN-1:0]   = st_q.ctrl.pin_en;
        ctrl_word[CTRL_ERRRESP] = st_q.ctrl.err_resp;
        ctrl_word[CTRL_ERRIRQ]  = st_q.ctrl.err_irq_en;
        ctrl_word[CTRL_PARCHK]  = st_q.ctrl.par_chk;

        stat_word = '0;
        stat_word[ST_NOTHOST]            = not_host_strap;
        stat_word[ST_MCAP]               = mst_cap_strap;
        stat_word[ST_MODE_LSB +: 2]      = mode_strap;
        stat_word[ST_EVT_LSB +: NEVT]    = st_q.events;
        stat_word[ST_PIN_LSB +: NPIN]    = pin_act_s;

        prdata = '0;
        if (psel && !pwrite) begin
            if (sel_ctrl)      prdata = ctrl_word;
            else if (sel_stat) prdata = stat_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o         = st_q.irq;
    assign err_irq_o     = st_q.err_irq;
    assign err_resp_en_o = st_q.ctrl.err_resp;
    assign par_chk_en_o  = st_q.ctrl.par_chk;
    assign host_ok_o     = !not_host_strap && mst_cap_strap;
endmodule

// File: rtl/pci_irq_router_chk.sv
module pci_irq_router_chk
    import pci_irq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            psel,
    input logic            penable,
    input logic            pwrite,
    input logic [1:0]      mode_i,
    input logic [NPIN-1:0] irq_i,
    input logic            err_irq_i,
    input logic [NPIN-1:0] pin_en_i,
    input logic            err_en_i,
    input logic [NEVT-1:0] events_i,
    input logic [2:0]      dev_pin_i,
    input logic            vld_i
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_i == '0) && !err_irq_i);

    // R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && penable && pwrite) |=> ((events_i & $past(events_i)) == $past(events_i)));

    // R5
    shared_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i[1] && $stable(mode_i)) |-> (irq_i[NPIN-1:1] == '0));

    // R6
    separate_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[1] && $stable(mode_i)) |-> ((irq_i & ~pin_en_i) == '0));

    // R7
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq_i |-> (err_en_i && |(events_i & ERR_EVT_MASK)));

    // R9
    no_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_pin_i == 3'd0) |-> !vld_i);
endmodule

bind pci_irq_router pci_irq_router_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .mode_i    (mode_strap),
    .irq_i     (irq_o),
    .err_irq_i (err_irq_o),
    .pin_en_i  (st_q.ctrl.pin_en),
    .err_en_i  (st_q.ctrl.err_irq_en),
    .events_i  (st_q.events),
    .dev_pin_i (dev_pin_i),
    .vld_i     (host_pin_vld_o)
);

// File: tb/sim_pci_irq_router.sv
`timescale 1ns/1ps
module sim_pci_irq_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [3:0]  pci_int_n = 4'hF;
    logic [5:0]  evt_i = '0;
    logic [1:0]  mode_strap = 2'd2;
    logic        not_host_strap = 1'b0;
    logic        mst_cap_strap = 1'b1;
    logic [4:0]  slot_i = '0;
    logic [2:0]  dev_pin_i = '0;
    logic [1:0]  host_pin_o;
    logic        host_pin_vld_o;
    logic [3:0]  irq_o;
    logic        err_irq_o, err_resp_en_o, par_chk_en_o, host_ok_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] rd;

    always #10 clk = ~clk;

    pci_irq_router u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pci_int_n(pci_int_n),
        .evt_i(evt_i), .mode_strap(mode_strap), .not_host_strap(not_host_strap),
        .mst_cap_strap(mst_cap_strap), .slot_i(slot_i), .dev_pin_i(dev_pin_i),
        .host_pin_o(host_pin_o), .host_pin_vld_o(host_pin_vld_o), .irq_o(irq_o),
        .err_irq_o(err_irq_o), .err_resp_en_o(err_resp_en_o),
        .par_chk_en_o(par_chk_en_o), .host_ok_o(host_ok_o)
    );

    // {mode[1:0], enable[3:0], lines low[3:0], expected irq[3:0]}
    localparam logic [13:0] VEC [8] = '{
        {2'd0, 4'hF, 4'b0001, 4'b0001},
        {2'd0, 4'hE, 4'b0001, 4'b0000},
        {2'd1, 4'h8, 4'b1000, 4'b0001},
        {2'd2, 4'hF, 4'b0101, 4'b0101},
        {2'd3, 4'h6, 4'b1111, 4'b0110},
        {2'd2, 4'hF, 4'b0000, 4'b0000},
        {2'd1, 4'hF, 4'b1110, 4'b0001},
        {2'd3, 4'h9, 4'b1001, 4'b1001}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d, input logic [5:0] ev);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1; evt_i = ev;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0; evt_i = '0;
    endtask

    task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1; pwrite = 0; penable = 0; paddr = a;
        #1 d = prdata;
        @(negedge clk);
        psel = 0;
    endtask

    task automatic pulse(input logic [5:0] ev);
        @(negedge clk);
        evt_i = ev;
        @(negedge clk);
        evt_i = '0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        apb_rd(8'h00, rd); chk("R1 ctrl", rd, 32'h0);
        apb_rd(8'h04, rd); chk("R1 status", rd, 32'h4200_0000);
        chk("R1 irq", {27'd0, err_irq_o, irq_o}, 32'h0);

        // R8 straps
        chk("R8 host_ok", host_ok_o, 1);
        not_host_strap = 1; mode_strap = 2'd1;
        apb_rd(8'h04, rd); chk("R8 status", rd, 32'hC100_0000);
        chk("R8 host_ok off", host_ok_o, 0);
        not_host_strap = 0; mst_cap_strap = 0;
        #1 chk("R8 no master", host_ok_o, 0);
        mst_cap_strap = 1; mode_strap = 2'd2;

        // R2 control register
        apb_wr(8'h00, 32'hFFFF_FFFF, 6'd0);
        apb_rd(8'h00, rd); chk("R2 readback", rd, 32'h0700_000F);
        chk("R2 outputs", {err_resp_en_o, par_chk_en_o}, 2'b11);
        apb_wr(8'h00, 32'h0100_0000, 6'd0);
        apb_rd(8'h00, rd); chk("R2 readback2", rd, 32'h0100_0000);
        chk("R2 outputs2", {err_resp_en_o, par_chk_en_o}, 2'b10);

        // R3 R5 R6 vector walk
        foreach (VEC[i]) begin
            mode_strap = VEC[i][13:12];
            apb_wr(8'h00, {28'd0, VEC[i][11:8]}, 6'd0);
            pci_int_n = ~VEC[i][7:4];
            repeat (4) @(negedge clk);
            chk(VEC[i][13] ? "R6 irq" : "R5 irq", irq_o, VEC[i][3:0]);
            apb_rd(8'h04, rd);
            chk("R3 line state", rd[11:8], VEC[i][7:4]);
        end
        pci_int_n = 4'hF; mode_strap = 2'd2;
        apb_wr(8'h00, 32'h0, 6'd0);
        repeat (4) @(negedge clk);

        // R4 sticky events
        pulse(6'b000001);
        apb_rd(8'h04, rd); chk("R4 set parity", rd[17:12], 6'b000001);
        pulse(6'b010000);
        apb_rd(8'h04, rd); chk("R4 accumulate", rd[17:12], 6'b010001);
        repeat (3) @(negedge clk);
        apb_rd(8'h04, rd); chk("R4 hold", rd[17:12], 6'b010001);
        apb_wr(8'h04, 32'h0000_1000, 6'd0);
        apb_rd(8'h04, rd); chk("R4 w1c", rd[17:12], 6'b010000);
        apb_wr(8'h04, 32'h0, 6'd0);
        apb_rd(8'h04, rd); chk("R4 write zero", rd[17:12], 6'b010000);
        apb_wr(8'h04, 32'h0001_0000, 6'b010000);
        apb_rd(8'h04, rd); chk("R4 set wins", rd[17:12], 6'b010000);
        apb_wr(8'h04, 32'h0003_F000, 6'd0);
        apb_rd(8'h04, rd); chk("R4 clear all", rd[17:12], 6'b000000);

        // R7 error interrupt
        apb_wr(8'h00, 32'h0200_0000, 6'd0);
        chk("R7 idle", err_irq_o, 0);
        pulse(6'b000100);
        chk("R7 master abort", err_irq_o, 1);
        apb_wr(8'h04, 32'h0000_4000, 6'd0);
        chk("R7 cleared", err_irq_o, 0);
        pulse(6'b011000);
        chk("R7 dma ignored", err_irq_o, 0);
        apb_rd(8'h04, rd); chk("R7 dma bits", rd[17:12], 6'b011000);
        pulse(6'b100000);
        chk("R7 system error", err_irq_o, 1);
        apb_wr(8'h00, 32'h0, 6'd0);
        chk("R7 enable off", err_irq_o, 0);
        apb_wr(8'h04, 32'h0003_F000, 6'd0);

        // R10 writes with no effect
        apb_wr(8'h00, 32'h0000_0005, 6'd0);
        apb_wr(8'h04, 32'hFFFC_0FFF, 6'd0);
        apb_rd(8'h04, rd); chk("R10 status ro", rd, 32'h4200_0000);
        apb_wr(8'h08, 32'hFFFF_FFFF, 6'd0);
        apb_rd(8'h00, rd); chk("R10 unmapped write", rd, 32'h0000_0005);
        apb_rd(8'h08, rd); chk("R10 unmapped read", rd, 32'h0);

        // R9 slot rotation
        for (int s = 0; s < 8; s++) begin
            for (int d = 0; d < 8; d++) begin
                logic       ev;
                logic [1:0] eh;
                @(negedge clk);
                slot_i = 5'(s); dev_pin_i = 3'(d);
                ev = (d >= 1) && (d <= 4);
                eh = ev ? 2'(((d - 1) + s) % 4) : 2'd0;
                #1 chk("R9 rotate", {host_pin_vld_o, host_pin_o}, {ev, eh});
            end
        end
        slot_i = 5'd17; dev_pin_i = 3'd4;
        #1 chk("R9 wide slot", {host_pin_vld_o, host_pin_o}, 3'b100);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule